// File: doc/BRIEF.md
# Parallel port register front end with interrupt

This block gives a host a three-register view of a legacy parallel printer port. A byte written at the data offset is driven onto the data pins, and a byte written at the control offset is driven onto the control pins. A read at the status offset returns the status pins after synchronization, with the three low bits forced to 1. A read at the unused fourth offset returns all ones. A write at the status offset or at the unused offset changes nothing. The host bus is synchronous and has a 2-bit offset, a read strobe, a write strobe and 8-bit data. Read data is registered and is valid in the cycle after the read strobe. In a PC-style system the block sits at I/O range 0x378 to 0x37B and its interrupt is routed to IRQ 7. That address decode and the routing are outside this block.

The main job of the block is the interrupt. The block is armed while control bit 4 (interrupt enable) is 1 and the active-low acknowledge input, reported in status bit 6, reads 0. A one-cycle interrupt pulse is produced when the armed condition goes from true to false. With the enable set, acknowledge rising from 0 to 1 therefore raises an interrupt. With acknowledge low, writing the control register with the enable cleared also raises an interrupt at once. The armed condition is evaluated every cycle from the control value as updated by any write in that cycle and from the synchronized acknowledge.

Top module: `pport_front`

## Requirements
- R1: After reset the data pins and the control pins are 0x00, and no interrupt pulse appears while the status pins are held steady.
- R2: A write at offset 0 drives the data pins in the next cycle. A read at offset 0 returns that byte in the cycle after the read strobe.
- R3: A write at offset 2 drives the control pins in the next cycle. A read at offset 2 returns that byte in the cycle after the read strobe.
- R4: A read at offset 1 returns the synchronized status pins with bits 2..0 forced to 1, in the cycle after the read strobe.
- R5: Writes at offsets 1 and 3 leave the data pins and the control pins unchanged. A read at offset 3 returns 0xFF.
- R6: With control bit 4 set, a 0-to-1 change on status pin 6 (acknowledge, active low) gives an interrupt pulse in the third cycle after the pin changes.
- R7: With status pin 6 at 0 and control bit 4 set, a control write that clears bit 4 gives an interrupt pulse in the cycle right after the write.
- R8: Each interrupt pulse is exactly one cycle long. No pulse follows a falling acknowledge, an acknowledge rise while bit 4 is 0, or clearing bit 4 while acknowledge is 1.
- R9: A status pin change is invisible to a read whose strobe falls within two cycles of the change. It is visible to a read issued two cycles after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ofs | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_data_o | output | 8 | Data pins |
| pin_ctrl_o | output | 8 | Control pins (bit 4 is the interrupt enable) |
| pin_stat_i | input | 8 | Status pins (bit 6 is the active-low acknowledge) |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Writes reach the pins one edge after the write strobe, and read data appears one edge after the read strobe. A control write that disarms the block pulses the interrupt on that same edge. A pin change crosses two synchronizer flops, so a status read sees it only when its strobe is issued two edges later, and an acknowledge-driven interrupt lands on the third edge. The bench drives inputs and samples outputs on falling edges. It checks the interrupt at each of these exact falling edges, including the ones just before and just after the pulse. It also counts every pulse seen, so that any extra pulse is caught.

// File: rtl/pport_pkg.sv
// Shared definitions for the parallel port front end.
// Assumes an 8-bit host bus and a 2-bit register offset.
package pport_pkg;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 2;

    // Register offsets seen by the host.
    typedef enum logic [OFS_W-1:0] {
        OFS_DATA = 2'd0,
        OFS_STAT = 2'd1,
        OFS_CTRL = 2'd2,
        OFS_NONE = 2'd3
    } pport_ofs_e;
endpackage

// File: rtl/pport_sync.sv
// Multi-stage synchronizer for a bus of asynchronous pins.
// Assumes each bit is treated independently (no bus coherence).
// On reset every stage holds RST_VAL.
module pport_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_i;
    end

    // Remaining stages shift the sampled value along.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pport_regs.sv
// Host register file: data and control latches plus the registered read mux.
// Assumes one strobe per cycle. Status writes and offset 3 writes are dropped.
// Exposes the control value as it will be after this cycle's write.
module pport_regs
    import pport_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STAT_FORCE = 8'h07,
    parameter logic [BYTE_W-1:0] NONE_READ  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [BYTE_W-1:0] stat_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [BYTE_W-1:0] data_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] ctrl_next_o
);
    logic [BYTE_W-1:0] data_q, ctrl_q, rdata_q, data_next, rsel;
    pport_ofs_e        ofs;

    assign ofs = pport_ofs_e'(ofs_i);

    // Next values of the writable latches.
    always_comb begin
        data_next   = data_q;
        ctrl_next_o = ctrl_q;
        if (wr_i && ofs == OFS_DATA) data_next   = wdata_i;
        if (wr_i && ofs == OFS_CTRL) ctrl_next_o = wdata_i;
    end

    // Read source selection.
    always_comb begin
        unique case (ofs)
            OFS_DATA: rsel = data_q;
            OFS_STAT: rsel = stat_i | STAT_FORCE;
            OFS_CTRL: rsel = ctrl_q;
            default:  rsel = NONE_READ;
        endcase
    end

    // Latch writes and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            ctrl_q  <= '0;
            rdata_q <= '0;
        end else begin
            data_q <= data_next;
            ctrl_q <= ctrl_next_o;
            if (rd_i) rdata_q <= rsel;
        end
    end

    assign data_o  = data_q;
    assign ctrl_o  = ctrl_q;
    assign rdata_o = rdata_q;

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (ofs_i == 2'd1 || ofs_i == 2'd3)) |=> ($stable(data_q) && $stable(ctrl_q))); // R5
    AST_NONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && ofs_i == 2'd3) |=> (rdata_q == 8'hFF)); // R5
    AST_STAT_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && ofs_i == 2'd1) |=> (rdata_q[2:0] == 3'b111)); // R4
endmodule

// File: rtl/pport_irq.sv
// Interrupt generator: tracks the armed condition (enable high, acknowledge low)
// and emits a one-cycle pulse when it falls.
// Assumes the acknowledge input is already synchronized.
module pport_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en_next_i,
    input  logic ack_n_i,
    output logic irq_o
);
    logic armed_q, irq_q, armed_now;

    // Armed condition from the post-write enable and the current acknowledge.
    assign armed_now = en_next_i && !ack_n_i;

    // Track the armed condition and pulse on its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            armed_q <= armed_now;
            irq_q   <= armed_q && !armed_now;
        end
    end

    assign irq_o = irq_q;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R8
endmodule

// File: rtl/pport_front.sv
// Parallel printer port front end: host registers, pin synchronizer and
// interrupt generator. Assumes the host offset is already decoded from the
// port's I/O range. Bit positions of enable and acknowledge are parameters.
module pport_front
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IEN_BIT     = 4,
    parameter int ACK_BIT     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] pin_data_o,
    output logic [BYTE_W-1:0] pin_ctrl_o,
    input  logic [BYTE_W-1:0] pin_stat_i,
    output logic              irq_o
);
    logic [BYTE_W-1:0] stat_sync, ctrl_next;

    pport_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_stat_i),
        .q_o   (stat_sync)
    );

    pport_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ofs_i       (bus_ofs),
        .rd_i        (bus_rd),
        .wr_i        (bus_wr),
        .wdata_i     (bus_wdata),
        .stat_i      (stat_sync),
        .rdata_o     (bus_rdata),
        .data_o      (pin_data_o),
        .ctrl_o      (pin_ctrl_o),
        .ctrl_next_o (ctrl_next)
    );

    pport_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_next_i (ctrl_next[IEN_BIT]),
        .ack_n_i   (stat_sync[ACK_BIT]),
        .irq_o     (irq_o)
    );

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(pin_ctrl_o[IEN_BIT])); // R6 R7
endmodule

// File: tb/sim_pport_front.sv
module sim_pport_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_ofs = 2'd0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, pin_data_o, pin_ctrl_o;
    logic [7:0] pin_stat_i = 8'hFF;
    logic       irq_o;

    int checks = 0, errors = 0, irq_seen = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    pport_front u0 (
        .clk(clk), .rst_n(rst_n), .bus_ofs(bus_ofs), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_data_o(pin_data_o), .pin_ctrl_o(pin_ctrl_o),
        .pin_stat_i(pin_stat_i), .irq_o(irq_o)
    );

    // Count interrupt pulses away from the active edge.
    always @(negedge clk) if (rst_n && irq_o) irq_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] o, input logic [7:0] d);
        bus_ofs = o; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] o, output logic [7:0] d);
        bus_ofs = o; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 data", pin_data_o, 8'h00);
        chk("R1 ctrl", pin_ctrl_o, 8'h00);
        settle();
        chk("R1 no irq", irq_seen, 0);
    endtask

    task automatic t_data_ctrl();
        wr(2'd0, 8'hA5);
        chk("R2 data pins", pin_data_o, 8'hA5);
        rd(2'd0, rv);
        chk("R2 data read", rv, 8'hA5);
        wr(2'd0, 8'h3C);
        chk("R2 data pins 2", pin_data_o, 8'h3C);
        wr(2'd2, 8'h0B);
        chk("R3 ctrl pins", pin_ctrl_o, 8'h0B);
        rd(2'd2, rv);
        chk("R3 ctrl read", rv, 8'h0B);
    endtask

    task automatic t_ignored();
        wr(2'd1, 8'h55);
        wr(2'd3, 8'h66);
        chk("R5 data kept", pin_data_o, 8'h3C);
        chk("R5 ctrl kept", pin_ctrl_o, 8'h0B);
        rd(2'd3, rv);
        chk("R5 offset3 read", rv, 8'hFF);
    endtask

    task automatic t_status();
        pin_stat_i = 8'h80;
        settle();
        rd(2'd1, rv);
        chk("R4 status", rv, 8'h87);
        pin_stat_i = 8'h28;
        rd(2'd1, rv);
        chk("R9 read at 0 cycles", rv, 8'h87);
        pin_stat_i = 8'h50;
        @(negedge clk);
        rd(2'd1, rv);
        chk("R9 read at 1 cycle", rv, 8'h2F);
        pin_stat_i = 8'h00;
        repeat (2) @(negedge clk);
        rd(2'd1, rv);
        chk("R9 read at 2 cycles", rv, 8'h07);
    endtask

    task automatic t_ack_irq();
        int base;
        pin_stat_i = 8'h00;
        wr(2'd2, 8'h10);
        settle();
        chk("R8 no irq on arm", irq_seen, 0);
        base = irq_seen;
        pin_stat_i = 8'h40;
        @(negedge clk); chk("R6 edge1", irq_o, 0);
        @(negedge clk); chk("R6 edge2", irq_o, 0);
        @(negedge clk); chk("R6 edge3", irq_o, 1);
        @(negedge clk); chk("R8 pulse ends", irq_o, 0);
        settle();
        chk("R6 one pulse", irq_seen, base + 1);
        base = irq_seen;
        pin_stat_i = 8'h00;
        settle();
        chk("R8 ack fall no irq", irq_seen, base);
    endtask

    task automatic t_disable_irq();
        int base;
        base = irq_seen;
        wr(2'd2, 8'h00);
        chk("R7 irq on disable", irq_o, 1);
        @(negedge clk); chk("R8 pulse ends", irq_o, 0);
        settle();
        chk("R7 one pulse", irq_seen, base + 1);
        base = irq_seen;
        pin_stat_i = 8'h40;
        settle();
        chk("R8 ack rise disabled", irq_seen, base);
        wr(2'd2, 8'h10);
        wr(2'd2, 8'h00);
        settle();
        chk("R8 disable with ack high", irq_seen, base);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_ctrl();
        t_ignored();
        t_status();
        t_ack_irq();
        t_disable_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule